// File: doc/BRIEF.md
# Shadowed Speculative Register File

This block is a two-write, two-read register file in which every architectural register has one shadow twin at the same index. A compiler-scheduled pipeline may hoist instructions above one predicted conditional branch. Such a hoisted instruction is called boosted, and its result is held in the shadow bank. It stays there until that branch resolves. Each read port picks a bank. A shadow read of an entry that holds no speculative value falls back to the architectural value.

When the branch resolves as correctly predicted, all live shadow values move into the architectural bank on one clock edge, with no stall. When it resolves as mispredicted, every shadow entry is discarded on one edge. A boosted result that carries an exception is not reported when it is written. The block records it. At the next correctly predicted resolve, it squashes the shadow bank in place of a commit and pulses a replay request. The pipeline then re-runs the boosted work as ordinary instructions.

Top module: `boost_regfile`

## Requirements
- R1: After reset every architectural register reads 0, every shadow entry is empty (so a shadow read returns the architectural value, 0), and `replayReq` is 0.
- R2: A write with `wrBoost`=0 updates the architectural register at `wrIdx`. The new value is visible on an architectural read in the next cycle, and the shadow entry of that index is unchanged.
- R3: A write with `wrBoost`=1 and no resolve in the same cycle stores its data in the shadow entry at `wrIdx` and marks that entry live. The architectural register of that index keeps its value.
- R4: A read with `rdShadow`=1 returns the shadow value when that entry is live, otherwise the architectural value. A read with `rdShadow`=0 always returns the architectural value.
- R5: A resolve (`brResolve`=1) with `brCorrect`=1 and no recorded exception copies every live shadow entry into its architectural register on that single edge and leaves all shadow entries empty.
- R6: A resolve with `brCorrect`=0 empties every shadow entry, changes no architectural register, and raises no replay.
- R7: A boosted write with `wrExc`=1 is recorded and raises nothing on its own: `replayReq` stays 0 until a resolve. `wrExc` on a non-boosted write is ignored.
- R8: A correct resolve that finds a recorded exception, or one that arrives with a boosted excepting write in the same cycle, empties the shadow bank and changes no architectural register. It drives `replayReq` high for exactly the one cycle after that edge and clears the record.
- R9: A boosted write in the same cycle as a committing correct resolve goes to the architectural register. It takes priority over the shadow value committed to the same index.
- R10: A boosted write in the same cycle as a mispredicted resolve is dropped.
- R11: When both write ports target the same bank and index in one cycle, port 1's data is kept.
- R12: Both write ports can update different registers in the same cycle.
- R13: A mispredicted resolve clears a recorded exception, so a later correct resolve commits normally and raises no replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn0 | input | 1 | Write port 0 enable |
| wrIdx0 | input | IDX_W | Write port 0 register index |
| wrData0 | input | DATA_W | Write port 0 data |
| wrBoost0 | input | 1 | Write port 0 result is speculative |
| wrExc0 | input | 1 | Write port 0 result carries an exception |
| wrEn1 | input | 1 | Write port 1 enable |
| wrIdx1 | input | IDX_W | Write port 1 register index |
| wrData1 | input | DATA_W | Write port 1 data |
| wrBoost1 | input | 1 | Write port 1 result is speculative |
| wrExc1 | input | 1 | Write port 1 result carries an exception |
| rdIdx0 | input | IDX_W | Read port 0 index |
| rdShadow0 | input | 1 | Read port 0 selects the shadow bank |
| rdData0 | output | DATA_W | Read port 0 data (combinational) |
| rdIdx1 | input | IDX_W | Read port 1 index |
| rdShadow1 | input | 1 | Read port 1 selects the shadow bank |
| rdData1 | output | DATA_W | Read port 1 data (combinational) |
| brResolve | input | 1 | The predicted branch resolves this cycle |
| brCorrect | input | 1 | The prediction was correct (valid with brResolve) |
| replayReq | output | 1 | One-cycle request to re-run the boosted instructions |

## Verification
The bench builds the file with NUM_REGS=8 and DATA_W=16. With only eight entries, every scenario can be followed by a sweep of all indices through both banks. A sweep like this exposes a commit or squash that misses or over-reaches a single entry. The 16-bit width keeps every written value distinct, so a stale value or a lost port-priority decision shows up directly on the read data.

// File: rtl/boost_rf_pkg.sv
package boost_rf_pkg;

  localparam int NUM_WR = 2;
  localparam int NUM_RD = 2;

  // Strobes from the control unit to the storage datapath.
  typedef struct packed {
    logic commit;      // copy live shadow entries into the architectural bank
    logic squash;      // empty every shadow entry
    logic redirect;    // boosted writes this cycle go to the architectural bank
    logic shadowWrEn;  // boosted writes this cycle may land in the shadow bank
  } rfStrobe_t;

endpackage

// File: rtl/boost_rf_control.sv
module boost_rf_control
  import boost_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              brResolve,
  input  logic              brCorrect,
  input  logic [NUM_WR-1:0] wrEn,
  input  logic [NUM_WR-1:0] wrBoost,
  input  logic [NUM_WR-1:0] wrExc,
  output rfStrobe_t         strobe,
  output logic              replayReq
);

  logic excPendQ;
  logic replayQ;
  logic excSeen;
  logic excNow;

  always_comb begin
    excSeen = |(wrEn & wrBoost & wrExc);
    excNow  = excPendQ | excSeen;

    strobe.commit     = brResolve & brCorrect & ~excNow;
    strobe.squash     = brResolve & (~brCorrect | excNow);
    strobe.redirect   = brResolve & brCorrect & ~excNow;
    strobe.shadowWrEn = ~brResolve;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excPendQ <= 1'b0;
      replayQ  <= 1'b0;
    end else begin
      excPendQ <= brResolve ? 1'b0 : excNow;
      replayQ  <= brResolve & brCorrect & excNow;
    end
  end

  assign replayReq = replayQ;

endmodule

// File: rtl/boost_rf_datapath.sv
module boost_rf_datapath
  import boost_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rfStrobe_t                     strobe,
  input  logic [NUM_WR-1:0]             wrEn,
  input  logic [NUM_WR-1:0][IDX_W-1:0]  wrIdx,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wrData,
  input  logic [NUM_WR-1:0]             wrBoost,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rdIdx,
  input  logic [NUM_RD-1:0]             rdShadow,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData,
  output logic [NUM_REGS-1:0]           shadowValid
);

  logic [DATA_W-1:0] seqBank [NUM_REGS];
  logic [DATA_W-1:0] shBank  [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gEntry
    logic [DATA_W-1:0] seqQ, seqD, shQ, shD;
    logic              vQ, vD;

    always_comb begin
      seqD = seqQ;
      shD  = shQ;
      vD   = vQ;
      if (strobe.commit && vQ) seqD = shQ;
      if (strobe.commit || strobe.squash) vD = 1'b0;
      // Later port overrides earlier one on the same target.
      for (int p = 0; p < NUM_WR; p++) begin
        if (wrEn[p] && (wrIdx[p] == IDX_W'(g))) begin
          if (!wrBoost[p] || strobe.redirect) begin
            seqD = wrData[p];
          end else if (strobe.shadowWrEn) begin
            shD = wrData[p];
            vD  = 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        seqQ <= '0;
        shQ  <= '0;
        vQ   <= 1'b0;
      end else begin
        seqQ <= seqD;
        shQ  <= shD;
        vQ   <= vD;
      end
    end

    assign seqBank[g]     = seqQ;
    assign shBank[g]      = shQ;
    assign shadowValid[g] = vQ;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : gRead
    assign rdData[r] = (rdShadow[r] && shadowValid[rdIdx[r]])
                     ? shBank[rdIdx[r]] : seqBank[rdIdx[r]];
  end

endmodule

// File: rtl/boost_regfile.sv
module boost_regfile
  import boost_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn0,
  input  logic [IDX_W-1:0]  wrIdx0,
  input  logic [DATA_W-1:0] wrData0,
  input  logic              wrBoost0,
  input  logic              wrExc0,
  input  logic              wrEn1,
  input  logic [IDX_W-1:0]  wrIdx1,
  input  logic [DATA_W-1:0] wrData1,
  input  logic              wrBoost1,
  input  logic              wrExc1,
  input  logic [IDX_W-1:0]  rdIdx0,
  input  logic              rdShadow0,
  output logic [DATA_W-1:0] rdData0,
  input  logic [IDX_W-1:0]  rdIdx1,
  input  logic              rdShadow1,
  output logic [DATA_W-1:0] rdData1,
  input  logic              brResolve,
  input  logic              brCorrect,
  output logic              replayReq
);

  rfStrobe_t                     strobe;
  logic [NUM_REGS-1:0]           shadowValid;
  logic [NUM_RD-1:0][DATA_W-1:0] rdBus;

  boost_rf_control uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .brResolve (brResolve),
    .brCorrect (brCorrect),
    .wrEn      ({wrEn1, wrEn0}),
    .wrBoost   ({wrBoost1, wrBoost0}),
    .wrExc     ({wrExc1, wrExc0}),
    .strobe    (strobe),
    .replayReq (replayReq)
  );

  boost_rf_datapath #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrEn        ({wrEn1, wrEn0}),
    .wrIdx       ({wrIdx1, wrIdx0}),
    .wrData      ({wrData1, wrData0}),
    .wrBoost     ({wrBoost1, wrBoost0}),
    .rdIdx       ({rdIdx1, rdIdx0}),
    .rdShadow    ({rdShadow1, rdShadow0}),
    .rdData      (rdBus),
    .shadowValid (shadowValid)
  );

  assign rdData0 = rdBus[0];
  assign rdData1 = rdBus[1];

endmodule

// File: rtl/boost_rf_checker.sv
module boost_rf_checker
  import boost_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                brResolve,
  input logic                brCorrect,
  input logic                wrEn0,
  input logic                wrBoost0,
  input logic [IDX_W-1:0]    wrIdx0,
  input logic                replayReq,
  input logic [NUM_REGS-1:0] shadowValid,
  input rfStrobe_t           strobe
);

  // R8
  replay_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayReq |-> $past(brResolve && brCorrect));

  // R6
  mispredict_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brResolve && !brCorrect) |=> (shadowValid == '0) && !replayReq);

  // R5
  resolve_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    brResolve |=> (shadowValid == '0));

  // R3
  boost_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn0 && wrBoost0 && !brResolve) |=> shadowValid[$past(wrIdx0)]);

  // R7
  exc_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !brResolve |=> !replayReq);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.commit && strobe.squash) && !(strobe.shadowWrEn && brResolve));

endmodule

bind boost_regfile boost_rf_checker #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .brResolve   (brResolve),
  .brCorrect   (brCorrect),
  .wrEn0       (wrEn0),
  .wrBoost0    (wrBoost0),
  .wrIdx0      (wrIdx0),
  .replayReq   (replayReq),
  .shadowValid (shadowValid),
  .strobe      (strobe)
);

// File: tb/tb_boost_regfile.sv
`timescale 1ns/1ps
module tb_boost_regfile;

  localparam int NR = 8;
  localparam int DW = 16;
  localparam int IW = $clog2(NR);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          wrEn0 = 0, wrBoost0 = 0, wrExc0 = 0;
  logic [IW-1:0] wrIdx0 = '0;
  logic [DW-1:0] wrData0 = '0;
  logic          wrEn1 = 0, wrBoost1 = 0, wrExc1 = 0;
  logic [IW-1:0] wrIdx1 = '0;
  logic [DW-1:0] wrData1 = '0;
  logic [IW-1:0] rdIdx0 = '0, rdIdx1 = '0;
  logic          rdShadow0 = 0, rdShadow1 = 0;
  logic [DW-1:0] rdData0, rdData1;
  logic          brResolve = 0, brCorrect = 0;
  logic          replayReq;

  boost_regfile #(.NUM_REGS(NR), .DATA_W(DW)) dut (.*);

  typedef struct {
    int    port;   // 0,1 = read ports, 2 = replay
    int    exp;
    string tag;
  } item_t;
  item_t q[$];

  typedef struct {
    bit en; int idx; int data; bit boost; bit exc;
  } wop_t;
  localparam wop_t NOP = '{0, 0, 0, 0, 0};

  int checks = 0, errors = 0;
  bit done = 0;

  // Requirement-level model
  int mSeq [NR];
  int mSh  [NR];
  bit mVal [NR];
  bit mExc = 0, mReplay = 0;

  // Monitor: compares queued expectations at the falling edge
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = (it.port == 0) ? int'(rdData0) : (it.port == 1) ? int'(rdData1) : int'(replayReq);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
      end
    end
  end

  task automatic setPort(int p, wop_t w);
    if (p == 0) begin
      wrEn0 = w.en; wrIdx0 = IW'(w.idx); wrData0 = DW'(w.data); wrBoost0 = w.boost; wrExc0 = w.exc;
    end else begin
      wrEn1 = w.en; wrIdx1 = IW'(w.idx); wrData1 = DW'(w.data); wrBoost1 = w.boost; wrExc1 = w.exc;
    end
  endtask

  // One cycle of stimulus; model advanced per the requirements
  task automatic doCycle(wop_t w0, wop_t w1, bit res, bit cor);
    bit excNow, commit;
    wop_t ws[2];
    setPort(0, w0); setPort(1, w1);
    brResolve = res; brCorrect = cor;
    @(posedge clk); #1;
    ws[0] = w0; ws[1] = w1;
    excNow = mExc || (w0.en && w0.boost && w0.exc) || (w1.en && w1.boost && w1.exc);
    commit = res && cor && !excNow;
    if (commit) for (int i = 0; i < NR; i++) if (mVal[i]) mSeq[i] = mSh[i];
    if (res) for (int i = 0; i < NR; i++) mVal[i] = 0;
    for (int p = 0; p < 2; p++) begin
      if (ws[p].en) begin
        if (!ws[p].boost || commit) mSeq[ws[p].idx] = ws[p].data & 16'hFFFF;
        else if (!res) begin mSh[ws[p].idx] = ws[p].data & 16'hFFFF; mVal[ws[p].idx] = 1; end
      end
    end
    mExc = res ? 0 : excNow;
    mReplay = res && cor && excNow;
    setPort(0, NOP); setPort(1, NOP);
    brResolve = 0; brCorrect = 0;
  endtask

  // Read every index: port 0 architectural, port 1 shadow; also replay
  task automatic checkAll(string tag);
    for (int i = 0; i < NR; i++) begin
      item_t it;
      rdIdx0 = IW'(i); rdShadow0 = 0;
      rdIdx1 = IW'(i); rdShadow1 = 1;
      it.tag = tag;
      it.port = 0; it.exp = mSeq[i]; q.push_back(it);
      it.port = 1; it.exp = mVal[i] ? mSh[i] : mSeq[i]; q.push_back(it);
      it.port = 2; it.exp = int'(mReplay); q.push_back(it);
      mReplay = 0;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin mSeq[i] = 0; mSh[i] = 0; mVal[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    checkAll("R1");
    // R12 / R2: two architectural writes in one cycle
    doCycle('{1, 1, 'h1111, 0, 0}, '{1, 2, 'h2222, 0, 0}, 0, 0);
    checkAll("R12");
    // R3 / R4: boosted writes on both ports; R7 wrExc ignored when not boosted
    doCycle('{1, 1, 'hA1A1, 1, 0}, '{1, 3, 'hB3B3, 1, 0}, 0, 0);
    doCycle('{1, 4, 'h0404, 0, 1}, NOP, 0, 0);
    checkAll("R3_R4");
    // R2: architectural write leaves live shadow intact
    doCycle('{1, 1, 'h5555, 0, 0}, NOP, 0, 0);
    checkAll("R2");
    // R5: bulk commit
    doCycle(NOP, NOP, 1, 1);
    checkAll("R5");
    // R6: bulk squash
    doCycle('{1, 4, 'hC4C4, 1, 0}, '{1, 5, 'hD5D5, 1, 0}, 0, 0);
    doCycle(NOP, NOP, 1, 0);
    checkAll("R6");
    // R7 then R8: deferred exception, replay at correct resolve
    doCycle('{1, 6, 'hE6E6, 1, 1}, '{1, 0, 'h0F0F, 1, 0}, 0, 0);
    checkAll("R7");
    doCycle(NOP, NOP, 1, 1);
    checkAll("R8");
    // R9: boosted writes redirected during commit, override committed shadow
    doCycle('{1, 2, 'h2A2A, 1, 0}, NOP, 0, 0);
    doCycle('{1, 7, 'h8888, 1, 0}, '{1, 2, 'h7777, 1, 0}, 1, 1);
    checkAll("R9");
    // R10: boosted write during mispredict dropped
    doCycle('{1, 3, 'h3C3C, 1, 0}, NOP, 1, 0);
    checkAll("R10");
    // R11: same target on both ports, both banks
    doCycle('{1, 5, 'h1234, 0, 0}, '{1, 5, 'h4321, 0, 0}, 0, 0);
    doCycle('{1, 6, 'h6000, 1, 0}, '{1, 6, 'h6111, 1, 0}, 0, 0);
    checkAll("R11");
    // R13: mispredict clears recorded exception
    doCycle('{1, 0, 'hDEAD, 1, 1}, NOP, 0, 0);
    doCycle(NOP, NOP, 1, 0);
    doCycle('{1, 0, 'hBEEF, 1, 0}, NOP, 0, 0);
    doCycle(NOP, NOP, 1, 1);
    checkAll("R13");
    // R8: exception arriving in the resolve cycle itself
    doCycle('{1, 4, 'h4444, 1, 0}, NOP, 0, 0);
    doCycle(NOP, '{1, 3, 'h3333, 1, 1}, 1, 1);
    checkAll("R8_same_cycle");
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule